// File: doc/BRIEF.md
# Fence Completion Notifier

This unit sits behind the command-queue processor of an I/O memory management unit. It takes one decoded fence command. The command carries a store-request flag, a wired-interrupt-request flag, a byte address and a 32-bit data word. The unit holds the command until the processor reports that every earlier command has drained. It then carries out the notifications the command asks for: a single aligned 32-bit memory store, a sticky fence-completion interrupt-pending bit, both, or neither.

A wired-interrupt request is legal only while wired-signaled interrupts are enabled in the configuration input. If the mode is off, the command is rejected. The unit raises a sticky illegal flag, performs no notification and stalls until software clears the flag. When a command asks for both the store and the interrupt, both take place. No order between them is promised, and a consumer must accept either one becoming visible first.

Top module: `fence_notify_unit`

## Requirements
- R1: `cmd_ready` is high only while the unit is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` stays low from the next cycle until that command has finished (done) or its illegal state has been cleared.
- R2: No notification happens while `prior_drained` is low. `wr_req`, `irq_pending` and `done` stay unchanged by the held command until the unit sees `prior_drained` high.
- R3: When `cmd_store` is 1, exactly one write request is issued. `wr_addr` equals `cmd_addr` with bits [1:0] forced to 0, and `wr_data` equals `cmd_data`.
- R4: Once raised, `wr_req` stays high with stable `wr_addr` and `wr_data` until a cycle in which `wr_ack` is high. It drops in the cycle after that edge.
- R5: When `cmd_irq` is 1 and `cfg_wire_irq_en` is 1, `irq_pending` becomes 1 one cycle after the drain edge. It stays 1 until a cycle with `irq_clear` high, after which it reads 0.
- R6: When `cmd_irq` is 1 and `cfg_wire_irq_en` is 0, the command is illegal. No write request is issued, `irq_pending` is not set and `done` does not pulse. `illegal` becomes 1 and stays 1, with `cmd_ready` low, until `illegal_clear` is pulsed. After that, `illegal` reads 0 and `cmd_ready` reads 1.
- R7: When both flags are set and wired mode is enabled, both the store and the pending bit take place before `done`, in either order.
- R8: When neither flag is set, `done` is high in the cycle right after the edge at which `prior_drained` is first seen high.
- R9: `done` is a single-cycle pulse. It comes only after the requested store has been acknowledged and the requested pending bit has been set.
- R10: A command with `cmd_irq` = 0 leaves `irq_pending` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Fence command offered |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_store | input | 1 | Command asks for a completion store |
| cmd_irq | input | 1 | Command asks for a wired interrupt |
| cmd_addr | input | ADDR_W | Store byte address; the low two bits are ignored |
| cmd_data | input | DATA_W | Value to store |
| cfg_wire_irq_en | input | 1 | Wired-signaled interrupts enabled |
| prior_drained | input | 1 | All earlier commands have completed |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write accepted |
| irq_pending | output | 1 | Sticky fence-completion interrupt pending |
| irq_clear | input | 1 | Write-1-to-clear for the pending bit |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Sticky illegal-command flag |
| illegal_clear | input | 1 | Clears the illegal flag and releases the stall |

## Verification
The bench sweeps all eight combinations of the store flag, the interrupt flag and the wired-mode enable. Each combination runs under three acknowledge latencies and two drain latencies. The flag combinations separate the legal paths (store only, interrupt only, both, neither) from the rejected path where an interrupt is asked for with wired mode off. The latency variations show whether done waits for the acknowledge and whether anything leaks out before the drain. In the combined case, the bench records which notification appears first and accepts either order, checking only that both appear before done.

// File: rtl/fn_pkg.sv
package fn_pkg;

    localparam int FN_ADDR_W = 64;
    localparam int FN_DATA_W = 32;

    typedef enum logic [1:0] {
        FN_IDLE  = 2'd0,
        FN_WAIT  = 2'd1,
        FN_STORE = 2'd2,
        FN_HALT  = 2'd3
    } fn_state_e;

    typedef struct packed {
        logic want_store;
        logic want_irq;
        logic bad;
    } fn_plan_t;

    function automatic fn_plan_t fn_decode(input logic st, input logic irq, input logic wire_en);
        fn_plan_t p;
        p.bad        = irq && !wire_en;
        p.want_store = st && !p.bad;
        p.want_irq   = irq && !p.bad;
        return p;
    endfunction

endpackage

// File: rtl/fn_cmd_hold.sv
module fn_cmd_hold #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              in_store,
    input  logic              in_irq,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              h_store,
    output logic              h_irq,
    output logic [ADDR_W-1:0] h_addr,
    output logic [DATA_W-1:0] h_data
);
    localparam int LOW_BITS = 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_store <= 1'b0;
            h_irq   <= 1'b0;
            h_addr  <= '0;
            h_data  <= '0;
        end else if (load) begin
            h_store <= in_store;
            h_irq   <= in_irq;
            h_addr  <= {in_addr[ADDR_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
            h_data  <= in_data;
        end
    end
endmodule

// File: rtl/fn_store_port.sv
module fn_store_port #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              wr_ack,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              finished
);
    assign finished = wr_req && wr_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (start && !wr_req) begin
            wr_req  <= 1'b1;
            wr_addr <= addr;
            wr_data <= data;
        end else if (finished) begin
            wr_req <= 1'b0;
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> wr_addr[1:0] == 2'b00);
endmodule

// File: rtl/fn_sticky_bit.sv
module fn_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        q && !clr |=> q);
endmodule

// File: rtl/fence_notify_unit.sv
module fence_notify_unit
    import fn_pkg::*;
#(
    parameter int ADDR_W = FN_ADDR_W,
    parameter int DATA_W = FN_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_store,
    input  logic              cmd_irq,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cfg_wire_irq_en,
    input  logic              prior_drained,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              irq_pending,
    input  logic              irq_clear,
    output logic              done,
    input  logic              illegal_clear,
    output logic              illegal
);
    fn_state_e st, st_nx;
    fn_plan_t  plan;

    logic              h_store, h_irq;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    logic              accept, go, store_fin, done_q;
    logic              store_start, irq_set, ill_set;

    assign cmd_ready = (st == FN_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign go        = (st == FN_WAIT) && prior_drained;
    assign plan      = fn_decode(h_store, h_irq, cfg_wire_irq_en);

    assign store_start = go && plan.want_store;
    assign irq_set     = go && plan.want_irq;
    assign ill_set     = go && plan.bad;

    fn_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .load(accept),
        .in_store(cmd_store), .in_irq(cmd_irq),
        .in_addr(cmd_addr), .in_data(cmd_data),
        .h_store(h_store), .h_irq(h_irq), .h_addr(h_addr), .h_data(h_data)
    );

    fn_store_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .start(store_start),
        .addr(h_addr), .data(h_data), .wr_ack(wr_ack),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .finished(store_fin)
    );

    fn_sticky_bit u_irq (
        .clk(clk), .rst(rst), .set(irq_set), .clr(irq_clear), .q(irq_pending)
    );

    fn_sticky_bit u_ill (
        .clk(clk), .rst(rst), .set(ill_set), .clr(illegal_clear), .q(illegal)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            FN_IDLE:  if (accept) st_nx = FN_WAIT;
            FN_WAIT:  if (go) begin
                          if (plan.bad)             st_nx = FN_HALT;
                          else if (plan.want_store) st_nx = FN_STORE;
                          else                      st_nx = FN_IDLE;
                      end
            FN_STORE: if (store_fin) st_nx = FN_IDLE;
            FN_HALT:  if (illegal_clear) st_nx = FN_IDLE;
            default:  st_nx = FN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FN_IDLE;
            done_q <= 1'b0;
        end else begin
            st     <= st_nx;
            done_q <= (go && !plan.bad && !plan.want_store)
                   || ((st == FN_STORE) && store_fin);
        end
    end

    assign done = done_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

    // R2
    hold_before_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FN_WAIT) && !prior_drained && !wr_req |=> !wr_req && !done);

    // R6
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(illegal) |-> !wr_req && !done && !cmd_ready);

    // R9
    done_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_req);
endmodule

// File: tb/tb_fence_notify_unit.sv
module tb_fence_notify_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0, cmd_store = 1'b0, cmd_irq = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          cfg_wire_irq_en = 1'b0, prior_drained = 1'b0;
    logic          wr_ack = 1'b0, irq_clear = 1'b0, illegal_clear = 1'b0;
    logic          cmd_ready, wr_req, irq_pending, done, illegal;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fence_notify_unit dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_store(cmd_store), .cmd_irq(cmd_irq), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cfg_wire_irq_en(cfg_wire_irq_en),
        .prior_drained(prior_drained), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .irq_pending(irq_pending),
        .irq_clear(irq_clear), .done(done), .illegal_clear(illegal_clear),
        .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input bit av, input bit wsi, input bit en,
                            input int ackd, input int drd, input int idx);
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit expect_bad;
        bit req_seen, irq_seen, done_seen, acked;
        int req_cyc, first_req, first_irq;
        a = 64'hC3A5_0000_1000_0003 + 64'(idx) * 64'h0001_0000_0000_0105;
        d = 32'h5A00_0000 ^ (32'(idx) * 32'h0101_0101);
        expect_bad = wsi && !en;
        prior_drained   = 1'b0;
        cfg_wire_irq_en = en;
        check(cmd_ready == 1'b1, "R1", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_store = av; cmd_irq = wsi; cmd_addr = a; cmd_data = d;
        tick();
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R1", cmd_ready, 0);
        for (int i = 0; i < drd; i++) begin
            check(!wr_req && !irq_pending && !done, "R2", {wr_req, irq_pending, done}, 0);
            tick();
        end
        prior_drained = 1'b1;
        req_seen = 0; irq_seen = 0; done_seen = 0; acked = 0;
        req_cyc = 0; first_req = -1; first_irq = -1;
        for (int c = 1; c <= 40 && !done_seen; c++) begin
            tick();
            wr_ack = 1'b0;
            if (irq_pending && !irq_seen) begin irq_seen = 1; first_irq = c; end
            if (wr_req) begin
                if (!req_seen) begin
                    req_seen = 1; first_req = c;
                    // R3 address alignment and data
                    check(wr_addr == {a[AW-1:2], 2'b00}, "R3", wr_addr, {a[AW-1:2], 2'b00});
                    check(wr_data == d, "R3", wr_data, d);
                end else begin
                    check(wr_addr == {a[AW-1:2], 2'b00} && wr_data == d, "R4", wr_data, d);
                end
                if (acked) check(0, "R4", 1, 0);
                if (req_cyc >= ackd) begin wr_ack = 1'b1; acked = 1; end
                req_cyc++;
            end
            if (done) begin
                done_seen = 1;
                if (!av && !wsi) check(c == 1, "R8", c, 1);
                check(acked == av, "R9", acked, av);
                check(irq_pending == wsi, "R9", irq_pending, wsi);
            end
            if (expect_bad && c >= 3) break;
        end
        wr_ack = 1'b0;
        if (expect_bad) begin
            check(illegal && !req_seen && !irq_seen && !done_seen && !cmd_ready, "R6",
                  {illegal, req_seen, irq_seen, done_seen, cmd_ready}, 5'b10000);
            tick();
            check(illegal && !cmd_ready, "R6", {illegal, cmd_ready}, 2'b10);
            illegal_clear = 1'b1;
            tick();
            illegal_clear = 1'b0;
            check(!illegal && cmd_ready, "R6", {illegal, cmd_ready}, 2'b01);
        end else begin
            check(done_seen, "R9", done_seen, 1);
            tick();
            check(!done, "R9", done, 0);
            check(req_seen == av, "R3", req_seen, av);
            if (!wsi) check(!irq_pending, "R10", irq_pending, 0);
            else      check(irq_pending, "R5", irq_pending, 1);
            // R7: both notifications required, any order accepted
            if (av && wsi) check(first_req > 0 && first_irq > 0, "R7", {first_req > 0, first_irq > 0}, 2'b11);
            tick();
            if (wsi) check(irq_pending, "R5", irq_pending, 1);
            irq_clear = 1'b1;
            tick();
            irq_clear = 1'b0;
            check(!irq_pending, "R5", irq_pending, 0);
            check(cmd_ready, "R1", cmd_ready, 1);
        end
        check(!illegal, "R6", illegal, 0);
    endtask

    initial begin
        int idx;
        idx = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready && !wr_req && !irq_pending && !done && !illegal, "R1",
              {cmd_ready, wr_req, irq_pending, done, illegal}, 5'b10000);
        for (int f = 0; f < 8; f++)
            for (int ak = 0; ak < 3; ak++)
                for (int dr = 0; dr < 2; dr++) begin
                    run_case(f[0], f[1], f[2], (ak == 2) ? 3 : ak, dr * 2, idx);
                    idx++;
                end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule